// File: doc/BRIEF.md
# Ring Link Packet Router

This block is the packet-steering core of a ring link controller. It sits between one unidirectional ring input, one ring output and a backside bus that feeds a host bridge. A packet is one word whose top 16 bits carry the destination node ID. The upper 8 bits of that ID index two 256-entry bitmaps. The eject table decides whether a packet arriving from the ring leaves the ring toward the backside (receive queue) or travels on (bypass FIFO). The capture table decides whether a packet offered by the backside is taken into the send queue.

Every ring packet gets an echo one cycle later. The echo carries the destination ID, a busy bit when the packet was discarded, and a throttle bit when the receive queue holds more than a set number of packets. Backside packets get a one-hot response in the same cycle they are offered: taken, busy, or not taken. Not taken leaves the discard to a timeout elsewhere. Bypass and send traffic share the ring output, and bypass traffic goes first.

A small controller FSM sequences the block. CONFIG is entered at reset and is the only state in which table writes land. RUN moves packets. DRAIN stops accepting new packets while the queues empty. The transitions are: CONFIG to RUN when route_en rises; RUN to DRAIN when route_en falls; DRAIN to CONFIG once all three queues are empty; and DRAIN back to RUN if route_en returns before that.

Top module: `ring_router`

## Requirements
- R1: After reset the FSM is in CONFIG, both tables are all zero, no output is valid, and ring packets are answered with a busy echo and dropped. Backside packets get the not-taken response.
- R2: In RUN, a ring packet whose eject-table bit (index = data bits [DATA_W-1:DATA_W-8]) is 1 enters the receive queue. It appears on bk_rx_data unchanged and in arrival order, and its echo has busy=0.
- R3: In RUN, a ring packet whose eject-table bit is 0 enters the bypass FIFO. It leaves on ring_out_data unchanged and in order.
- R4: In RUN, a backside packet whose capture-table bit is 1, offered while the send queue has room, gets bk_tx_ack in the same cycle. It later leaves on ring_out_data unchanged.
- R5: A backside packet whose capture-table bit is 0, or one offered outside RUN, gets bk_tx_notaken and never appears on the ring output.
- R6: When the ring output is free to pick, a waiting bypass packet is presented before any send packet. A send packet that is already presented stays presented until it is taken.
- R7: A ring packet whose target queue (receive or bypass) is full is discarded and echoed with busy=1. A capturable backside packet offered while the send queue is full gets bk_tx_busy and is not stored.
- R8: An echo has throttle=1 exactly when the receive queue held more than THR_LVL packets in the cycle the ring packet arrived.
- R9: A table write (tbl_sel 0 = eject table, 1 = capture table) takes effect only in CONFIG. In any other state it leaves the table unchanged.
- R10: The FSM follows CONFIG to RUN to DRAIN to CONFIG, with DRAIN back to RUN on re-enable. In DRAIN, ring packets get busy echoes and backside packets get not-taken, while the queued packets still drain.
- R11: While an output is valid and not accepted, it stays valid with its data unchanged.
- R12: Every ring-input cycle produces exactly one echo in the next cycle, carrying that packet's 16-bit destination ID. No echo is produced otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| route_en | input | 1 | Routing enable; drives the FSM |
| tbl_we | input | 1 | Table write strobe |
| tbl_sel | input | 1 | 0 = eject table, 1 = capture table |
| tbl_idx | input | IDX_W | Table entry (node index) |
| tbl_bit | input | 1 | Value written to the entry |
| ring_in_valid | input | 1 | Ring packet present |
| ring_in_data | input | DATA_W | Ring packet, destination ID in top NODE_W bits |
| echo_valid | output | 1 | Echo for last cycle's ring packet |
| echo_busy | output | 1 | Packet was discarded |
| echo_throttle | output | 1 | Receive queue above threshold |
| echo_node | output | NODE_W | Destination ID of the echoed packet |
| ring_out_valid | output | 1 | Ring output packet present |
| ring_out_ready | input | 1 | Ring output accepted |
| ring_out_data | output | DATA_W | Ring output packet |
| bk_tx_valid | input | 1 | Backside packet offered |
| bk_tx_data | input | DATA_W | Backside packet |
| bk_tx_ack | output | 1 | Backside packet taken |
| bk_tx_busy | output | 1 | Capturable but send queue full |
| bk_tx_notaken | output | 1 | Not claimed by the capture table, or not in RUN |
| bk_rx_valid | output | 1 | Receive queue head present |
| bk_rx_ready | input | 1 | Backside accepts head |
| bk_rx_data | output | DATA_W | Receive queue head |

## Verification
The bench builds the router with QDEPTH=4, BYP_DEPTH=2 and THR_LVL=2. With these values a handful of packets fills the receive queue, the bypass FIFO and the send queue. The bench can therefore provoke busy echoes, busy responses and the throttle bit, and it can have both ring-output sources loaded at once to exercise output priority. Stalled readies hold queues non-empty, so DRAIN can be observed, together with its exit to CONFIG and its return to RUN.

// File: rtl/ring_router_pkg.sv
package ring_router_pkg;

    typedef enum logic [1:0] {
        ST_CONFIG = 2'd0,
        ST_RUN    = 2'd1,
        ST_DRAIN  = 2'd2
    } rr_state_e;

    typedef enum logic [2:0] {
        TXR_NONE    = 3'b000,
        TXR_TAKEN   = 3'b100,
        TXR_BUSY    = 3'b010,
        TXR_NOTAKEN = 3'b001
    } rr_txresp_e;

endpackage

// File: rtl/rr_fifo.sv
module rr_fifo #(
    parameter int W     = 32,
    parameter int DEPTH = 8,
    localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [W-1:0]  din,
    input  logic          pop,
    output logic [W-1:0]  dout,
    output logic          full,
    output logic [CW-1:0] count
);

    logic [W-1:0]  mem [DEPTH];
    logic [PW-1:0] wr_p, rd_p;

    function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (push) begin
            mem[wr_p] <= din;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_p  <= '0;
            rd_p  <= '0;
            count <= '0;
        end else begin
            if (push) wr_p <= bump(wr_p);
            if (pop)  rd_p <= bump(rd_p);
            count <= count + CW'(push) - CW'(pop);
        end
    end

    assign dout = mem[rd_p];
    assign full = (count == CW'(DEPTH));

endmodule

// File: rtl/rr_bitmap.sv
module rr_bitmap #(
    parameter int IDX_W    = 8,
    localparam int ENTRIES = 1 << IDX_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [IDX_W-1:0] widx,
    input  logic             wbit,
    input  logic [IDX_W-1:0] ridx,
    output logic             rbit
);

    logic [ENTRIES-1:0] map_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            map_q <= '0;
        end else if (we) begin
            map_q[widx] <= wbit;
        end
    end

    assign rbit = map_q[ridx];

endmodule

// File: rtl/rr_ctrl.sv
module rr_ctrl
    import ring_router_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      route_en,
    input  logic      all_empty,
    output rr_state_e state,
    output logic      accept_en,
    output logic      cfg_open
);

    rr_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_CONFIG: if (route_en) state_d = ST_RUN;
            ST_RUN:    if (!route_en) state_d = ST_DRAIN;
            ST_DRAIN: begin
                if (route_en)       state_d = ST_RUN;
                else if (all_empty) state_d = ST_CONFIG;
            end
            default:   state_d = ST_CONFIG;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_CONFIG;
        else        state_q <= state_d;
    end

    always_comb begin
        accept_en = 1'b0;
        cfg_open  = 1'b0;
        unique case (state_q)
            ST_CONFIG: cfg_open  = 1'b1;
            ST_RUN:    accept_en = 1'b1;
            ST_DRAIN:  accept_en = 1'b0;
            default:   cfg_open  = 1'b0;
        endcase
    end

    assign state = state_q;

endmodule

// File: rtl/ring_router.sv
module ring_router
    import ring_router_pkg::*;
#(
    parameter int DATA_W    = 32,
    parameter int NODE_W    = 16,
    parameter int IDX_W     = 8,
    parameter int QDEPTH    = 8,
    parameter int BYP_DEPTH = 4,
    parameter int THR_LVL   = (QDEPTH * 3) / 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              route_en,
    input  logic              tbl_we,
    input  logic              tbl_sel,
    input  logic [IDX_W-1:0]  tbl_idx,
    input  logic              tbl_bit,
    input  logic              ring_in_valid,
    input  logic [DATA_W-1:0] ring_in_data,
    output logic              echo_valid,
    output logic              echo_busy,
    output logic              echo_throttle,
    output logic [NODE_W-1:0] echo_node,
    output logic              ring_out_valid,
    input  logic              ring_out_ready,
    output logic [DATA_W-1:0] ring_out_data,
    input  logic              bk_tx_valid,
    input  logic [DATA_W-1:0] bk_tx_data,
    output logic              bk_tx_ack,
    output logic              bk_tx_busy,
    output logic              bk_tx_notaken,
    output logic              bk_rx_valid,
    input  logic              bk_rx_ready,
    output logic [DATA_W-1:0] bk_rx_data
);

    localparam int QCW = $clog2(QDEPTH + 1);
    localparam int BCW = $clog2(BYP_DEPTH + 1);
    localparam int NTBL = 2;

    rr_state_e state;
    logic      accept_en, cfg_open, all_empty;

    // ---------------- destination tables ----------------
    logic [NTBL-1:0]  t_we, t_hit;
    logic [IDX_W-1:0] t_ridx [NTBL];

    assign t_ridx[0] = ring_in_data[DATA_W-1 -: IDX_W];
    assign t_ridx[1] = bk_tx_data[DATA_W-1 -: IDX_W];

    for (genvar g = 0; g < NTBL; g++) begin : g_tbl
        assign t_we[g] = tbl_we & cfg_open & (tbl_sel == 1'(g));
        rr_bitmap #(.IDX_W(IDX_W)) u_map (
            .clk  (clk),
            .rst_n(rst_n),
            .we   (t_we[g]),
            .widx (tbl_idx),
            .wbit (tbl_bit),
            .ridx (t_ridx[g]),
            .rbit (t_hit[g])
        );
    end

    // ---------------- queues ----------------
    logic              rx_push, rx_pop, rx_full;
    logic [QCW-1:0]    rx_cnt;
    logic              byp_push, byp_pop, byp_full;
    logic [BCW-1:0]    byp_cnt;
    logic [DATA_W-1:0] byp_dout;
    logic              tx_push, tx_pop, tx_full;
    logic [QCW-1:0]    tx_cnt;
    logic [DATA_W-1:0] tx_dout;
    logic              rx_empty, byp_empty, tx_empty;

    rr_fifo #(.W(DATA_W), .DEPTH(QDEPTH)) u_rxq (
        .clk(clk), .rst_n(rst_n), .push(rx_push), .din(ring_in_data),
        .pop(rx_pop), .dout(bk_rx_data), .full(rx_full), .count(rx_cnt)
    );

    rr_fifo #(.W(DATA_W), .DEPTH(BYP_DEPTH)) u_bypq (
        .clk(clk), .rst_n(rst_n), .push(byp_push), .din(ring_in_data),
        .pop(byp_pop), .dout(byp_dout), .full(byp_full), .count(byp_cnt)
    );

    rr_fifo #(.W(DATA_W), .DEPTH(QDEPTH)) u_txq (
        .clk(clk), .rst_n(rst_n), .push(tx_push), .din(bk_tx_data),
        .pop(tx_pop), .dout(tx_dout), .full(tx_full), .count(tx_cnt)
    );

    assign rx_empty  = (rx_cnt == '0);
    assign byp_empty = (byp_cnt == '0);
    assign tx_empty  = (tx_cnt == '0);
    assign all_empty = rx_empty & byp_empty & tx_empty;

    // ---------------- sequencing FSM ----------------
    rr_ctrl u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .route_en (route_en),
        .all_empty(all_empty),
        .state    (state),
        .accept_en(accept_en),
        .cfg_open (cfg_open)
    );

    // ---------------- ring input steering and echo ----------------
    logic ring_drop;

    assign rx_push   = ring_in_valid & accept_en &  t_hit[0] & ~rx_full;
    assign byp_push  = ring_in_valid & accept_en & ~t_hit[0] & ~byp_full;
    assign ring_drop = ring_in_valid & ~(rx_push | byp_push);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            echo_valid    <= 1'b0;
            echo_busy     <= 1'b0;
            echo_throttle <= 1'b0;
            echo_node     <= '0;
        end else begin
            echo_valid    <= ring_in_valid;
            echo_busy     <= ring_drop;
            echo_throttle <= ring_in_valid & (rx_cnt > QCW'(THR_LVL));
            echo_node     <= ring_in_valid ? ring_in_data[DATA_W-1 -: NODE_W] : '0;
        end
    end

    // ---------------- backside capture ----------------
    rr_txresp_e tx_resp;

    always_comb begin
        if (!bk_tx_valid)                  tx_resp = TXR_NONE;
        else if (!(accept_en & t_hit[1])) tx_resp = TXR_NOTAKEN;
        else if (tx_full)                 tx_resp = TXR_BUSY;
        else                              tx_resp = TXR_TAKEN;
    end

    assign {bk_tx_ack, bk_tx_busy, bk_tx_notaken} = tx_resp;
    assign tx_push = bk_tx_ack;

    // ---------------- ring output merge ----------------
    logic lock_tx_q, show_tx;

    assign show_tx        = ~tx_empty & (lock_tx_q | byp_empty);
    assign ring_out_valid = ~byp_empty | ~tx_empty;
    assign ring_out_data  = show_tx ? tx_dout : byp_dout;
    assign tx_pop         = ring_out_ready & show_tx;
    assign byp_pop        = ring_out_ready & ~show_tx & ~byp_empty;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lock_tx_q <= 1'b0;
        else        lock_tx_q <= show_tx & ~ring_out_ready;
    end

    // ---------------- receive side ----------------
    assign bk_rx_valid = ~rx_empty;
    assign rx_pop      = bk_rx_ready & ~rx_empty;

endmodule

// File: rtl/ring_router_chk.sv
module ring_router_chk #(
    parameter int DATA_W = 32,
    parameter int NODE_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ring_in_valid,
    input logic [DATA_W-1:0] ring_in_data,
    input logic              echo_valid,
    input logic              echo_throttle,
    input logic [NODE_W-1:0] echo_node,
    input logic              ring_out_valid,
    input logic              ring_out_ready,
    input logic [DATA_W-1:0] ring_out_data,
    input logic              bk_tx_valid,
    input logic              bk_tx_ack,
    input logic              bk_tx_busy,
    input logic              bk_tx_notaken,
    input logic              bk_rx_valid,
    input logic              bk_rx_ready,
    input logic [DATA_W-1:0] bk_rx_data
);

    a_r11_rx_hold: assert property (@(posedge clk) disable iff (!rst_n)
        bk_rx_valid && !bk_rx_ready |=> bk_rx_valid && $stable(bk_rx_data));

    a_r11_out_hold: assert property (@(posedge clk) disable iff (!rst_n)
        ring_out_valid && !ring_out_ready |=> ring_out_valid && $stable(ring_out_data));

    a_r12_echo_follows: assert property (@(posedge clk) disable iff (!rst_n)
        ring_in_valid |=> echo_valid && (echo_node == $past(ring_in_data[DATA_W-1 -: NODE_W])));

    a_r12_no_stray_echo: assert property (@(posedge clk) disable iff (!rst_n)
        !ring_in_valid |=> !echo_valid);

    a_r4_one_response: assert property (@(posedge clk) disable iff (!rst_n)
        bk_tx_valid |-> $countones({bk_tx_ack, bk_tx_busy, bk_tx_notaken}) == 1);

    a_r5_quiet_response: assert property (@(posedge clk) disable iff (!rst_n)
        !bk_tx_valid |-> !bk_tx_ack && !bk_tx_busy && !bk_tx_notaken);

    a_r8_throttle_in_echo: assert property (@(posedge clk) disable iff (!rst_n)
        echo_throttle |-> echo_valid);

endmodule

bind ring_router ring_router_chk #(.DATA_W(DATA_W), .NODE_W(NODE_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .ring_in_valid (ring_in_valid),
    .ring_in_data  (ring_in_data),
    .echo_valid    (echo_valid),
    .echo_throttle (echo_throttle),
    .echo_node     (echo_node),
    .ring_out_valid(ring_out_valid),
    .ring_out_ready(ring_out_ready),
    .ring_out_data (ring_out_data),
    .bk_tx_valid   (bk_tx_valid),
    .bk_tx_ack     (bk_tx_ack),
    .bk_tx_busy    (bk_tx_busy),
    .bk_tx_notaken (bk_tx_notaken),
    .bk_rx_valid   (bk_rx_valid),
    .bk_rx_ready   (bk_rx_ready),
    .bk_rx_data    (bk_rx_data)
);

// File: tb/sim_ring_router.sv
module sim_ring_router;

    localparam int DW = 32;
    localparam int QD = 4;
    localparam int BD = 2;
    localparam int TH = 2;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic          rst_n = 1'b0;
    logic          route_en = 1'b0;
    logic          tbl_we = 1'b0, tbl_sel = 1'b0, tbl_bit = 1'b0;
    logic [7:0]    tbl_idx = '0;
    logic          ring_in_valid = 1'b0;
    logic [DW-1:0] ring_in_data = '0;
    logic          echo_valid, echo_busy, echo_throttle;
    logic [15:0]   echo_node;
    logic          ring_out_valid;
    logic          ring_out_ready = 1'b1;
    logic [DW-1:0] ring_out_data;
    logic          bk_tx_valid = 1'b0;
    logic [DW-1:0] bk_tx_data = '0;
    logic          bk_tx_ack, bk_tx_busy, bk_tx_notaken;
    logic          bk_rx_valid;
    logic          bk_rx_ready = 1'b1;
    logic [DW-1:0] bk_rx_data;

    ring_router #(.DATA_W(DW), .QDEPTH(QD), .BYP_DEPTH(BD), .THR_LVL(TH)) u0 (
        .clk(clk), .rst_n(rst_n), .route_en(route_en),
        .tbl_we(tbl_we), .tbl_sel(tbl_sel), .tbl_idx(tbl_idx), .tbl_bit(tbl_bit),
        .ring_in_valid(ring_in_valid), .ring_in_data(ring_in_data),
        .echo_valid(echo_valid), .echo_busy(echo_busy),
        .echo_throttle(echo_throttle), .echo_node(echo_node),
        .ring_out_valid(ring_out_valid), .ring_out_ready(ring_out_ready),
        .ring_out_data(ring_out_data),
        .bk_tx_valid(bk_tx_valid), .bk_tx_data(bk_tx_data),
        .bk_tx_ack(bk_tx_ack), .bk_tx_busy(bk_tx_busy), .bk_tx_notaken(bk_tx_notaken),
        .bk_rx_valid(bk_rx_valid), .bk_rx_ready(bk_rx_ready), .bk_rx_data(bk_rx_data)
    );

    int n_vec = 0;
    int n_bad = 0;

    logic [DW-1:0] exp_rx[$];
    logic [DW-1:0] exp_byp[$];
    logic [DW-1:0] exp_tx[$];
    logic [17:0]   exp_echo[$];
    bit            eject_m[256];
    bit            capt_m[256];
    bit            m_accept = 1'b0;
    bit            m_cfg = 1'b1;
    bit            m_lock = 1'b0;
    bit            mon_on = 1'b0;

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // scoreboard monitor
    always @(negedge clk) begin : mon
        bit            use_tx;
        logic [DW-1:0] e;
        if (mon_on) begin
            if (echo_valid) begin
                if (exp_echo.size() == 0) check("R12 unexpected echo", 1, 0);
                else check("R12 R7 R8 echo {busy,thr,node}",
                           {echo_busy, echo_throttle, echo_node}, exp_echo.pop_front());
            end
            if (bk_rx_valid) begin
                if (exp_rx.size() == 0) check("R2 unexpected receive", bk_rx_data, 0);
                else begin
                    check("R2 R11 receive head", bk_rx_data, exp_rx[0]);
                    if (bk_rx_ready) void'(exp_rx.pop_front());
                end
            end
            if (ring_out_valid) begin
                if (exp_byp.size() == 0 && exp_tx.size() == 0) begin
                    check("R5 unexpected ring output", ring_out_data, 0);
                end else begin
                    use_tx = (m_lock && exp_tx.size() > 0) || exp_byp.size() == 0;
                    e = use_tx ? exp_tx[0] : exp_byp[0];
                    check("R3 R4 R6 R11 ring output", ring_out_data, e);
                    if (ring_out_ready) begin
                        if (use_tx) void'(exp_tx.pop_front());
                        else        void'(exp_byp.pop_front());
                    end
                    m_lock = use_tx && !ring_out_ready;
                end
            end else begin
                m_lock = 1'b0;
            end
        end
    end

    task automatic ring_send(input logic [DW-1:0] d);
        logic [7:0] ix = d[DW-1 -: 8];
        bit to_rx, thr, busy;
        @(posedge clk); #1;
        ring_in_valid = 1'b1;
        ring_in_data  = d;
        to_rx = eject_m[ix];
        thr   = exp_rx.size() > TH;
        busy  = !m_accept || (to_rx ? exp_rx.size() >= QD : exp_byp.size() >= BD);
        @(posedge clk); #1;
        ring_in_valid = 1'b0;
        exp_echo.push_back({busy, thr, d[DW-1 -: 16]});
        if (!busy) begin
            if (to_rx) exp_rx.push_back(d);
            else       exp_byp.push_back(d);
        end
    endtask

    task automatic tx_send(input logic [DW-1:0] d);
        logic [7:0] ix = d[DW-1 -: 8];
        logic [2:0] er;
        @(posedge clk); #1;
        bk_tx_valid = 1'b1;
        bk_tx_data  = d;
        if (!m_accept || !capt_m[ix]) er = 3'b001;
        else if (exp_tx.size() >= QD)  er = 3'b010;
        else                           er = 3'b100;
        #2;
        check("R4 R5 R7 backside response {ack,busy,notaken}",
              {bk_tx_ack, bk_tx_busy, bk_tx_notaken}, er);
        @(posedge clk); #1;
        bk_tx_valid = 1'b0;
        if (er == 3'b100) exp_tx.push_back(d);
    endtask

    task automatic tbl_write(input bit sel, input logic [7:0] ix, input bit v);
        @(posedge clk); #1;
        tbl_we = 1'b1; tbl_sel = sel; tbl_idx = ix; tbl_bit = v;
        @(posedge clk); #1;
        tbl_we = 1'b0;
        if (m_cfg) begin
            if (sel) capt_m[ix] = v;
            else     eject_m[ix] = v;
        end
    endtask

    task automatic set_route(input bit v);
        @(posedge clk); #1;
        route_en = v;
        @(posedge clk); #1;
        m_accept = v;
        if (v) m_cfg = 1'b0;
    endtask

    task automatic wait_cycles(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_vec++;
        n_bad++;
        $display("FAIL watchdog R10: actual still running expected finished");
        finish_run();
    end

    initial begin : stim
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        check("R1 reset ring_out_valid", ring_out_valid, 0);
        check("R1 reset bk_rx_valid", bk_rx_valid, 0);
        check("R1 reset echo_valid", echo_valid, 0);
        mon_on = 1'b1;

        // R1: CONFIG drops everything
        ring_send(32'h3000_0001);
        tx_send(32'h4000_0002);

        // load tables in CONFIG
        tbl_write(1'b0, 8'h12, 1'b1);
        tbl_write(1'b0, 8'h13, 1'b1);
        tbl_write(1'b1, 8'h40, 1'b1);
        set_route(1'b1);

        // R9: write in RUN ignored
        tbl_write(1'b0, 8'h20, 1'b1);
        ring_send(32'h2000_0003);

        // R2, R3
        ring_send(32'h1200_0010);
        ring_send(32'h1301_0011);
        ring_send(32'h5500_0012);

        // R4, R5
        tx_send(32'h4000_0020);
        tx_send(32'h4100_0021);

        // R6: bypass goes first
        @(posedge clk); #1 ring_out_ready = 1'b0;
        fork
            ring_send(32'h5500_0030);
            tx_send(32'h4000_0031);
        join
        ring_send(32'h5600_0032);
        wait_cycles(2);
        ring_out_ready = 1'b1;
        wait_cycles(6);

        // R7, R8: fill receive queue
        bk_rx_ready = 1'b0;
        for (int i = 0; i < QD + 1; i++) ring_send(32'h1200_0100 + DW'(i));
        // R7: fill bypass and send queues
        ring_out_ready = 1'b0;
        for (int i = 0; i < BD + 1; i++) ring_send(32'h7700_0200 + DW'(i));
        for (int i = 0; i < QD + 1; i++) tx_send(32'h4000_0300 + DW'(i));
        wait_cycles(2);
        ring_out_ready = 1'b1;
        wait_cycles(10);

        // R10: DRAIN with receive queue still full
        set_route(1'b0);
        tbl_write(1'b0, 8'h66, 1'b1);
        ring_send(32'h1200_0400);
        tx_send(32'h4000_0401);
        bk_rx_ready = 1'b1;
        wait_cycles(10);
        m_cfg = 1'b1;
        tbl_write(1'b0, 8'h55, 1'b1);
        set_route(1'b1);
        ring_send(32'h6600_0500);
        ring_send(32'h5500_0501);

        // R10: DRAIN back to RUN on re-enable
        bk_rx_ready = 1'b0;
        ring_send(32'h1200_0600);
        set_route(1'b0);
        set_route(1'b1);
        ring_send(32'h1300_0601);
        tbl_write(1'b1, 8'h41, 1'b1);
        tx_send(32'h4100_0602);
        bk_rx_ready = 1'b1;
        wait_cycles(20);

        check("R2 receive items left", exp_rx.size(), 0);
        check("R3 bypass items left", exp_byp.size(), 0);
        check("R4 send items left", exp_tx.size(), 0);
        check("R12 echoes left", exp_echo.size(), 0);
        finish_run();
    end

endmodule